// File: doc/BRIEF.md
# Programmable-priority interrupt controller

This block gathers interrupt requests from 41 sources. Fifteen are encoded external lines, one is a non-maskable line and the rest are on-chip peripherals. Each source has a 4-bit priority. The external lines have fixed levels. The peripherals take their levels from three 16-bit priority registers, and some fields in those registers serve several related sources at once.

Requests arrive as one-cycle raise and clear strobes and are held in a pending vector. A registered compare tree picks the pending source with the highest priority and presents its exception code. It also drives a request to the CPU. That request is asserted only when the CPU has not blocked exceptions and the CPU's 4-bit mask level is strictly below the winner's priority.

The CPU reads the code of the current winner at any time. Reading the code does not remove the source. The source leaves the pending set only when its clear strobe is pulsed.

Top module: `prio_intc`

## Requirements
- R1: After reset, `pending_o`, `irq_o` and `win_valid_o` are 0, and all three priority registers read back as 0. Every peripheral source therefore starts disabled.
- R2: A raise of a source whose current priority is 0 is ignored: its `pending_o` bit stays 0.
- R3: Fixed priorities:
  - External line n (source index n, 0..14) has priority 15-n.
  - The non-maskable source (index 15) has priority 16, which is above every programmable level.
- R4: Register A sits at offset 0x004 and holds the following fields:
  - [15:12] timer 0 (index 23).
  - [11:8] timer 1 (index 24).
  - [7:4] timer 2 and its capture source (indices 25, 26).
  - [3:0] the three clock/calendar sources (indices 27..29).
- R5: Register B sits at offset 0x008 and holds the following fields:
  - [15:12] watchdog (index 38).
  - [11:8] both refresh sources (indices 39, 40).
  - [7:4] the four serial sources (indices 30..33).
  - Bits [3:0] are reserved. They read as 0 and ignore writes.
- R6: Register C sits at offset 0x00C and holds the following fields:
  - [15:12] GPIO (index 17).
  - [11:8] the four DMA-end sources and the DMA-error source (indices 18..22).
  - [7:4] the four FIFO-serial sources (indices 34..37).
  - [3:0] the debug source (index 16).
- R7: Exception codes:
  - Index n<15: 0x200+0x20·n.
  - Index 15: 0x1C0.
  - Indices 16..22: 0x600+0x20·(n-16).
  - Indices 23..33: 0x400+0x20·(n-23).
  - Indices 34..37: 0x700+0x20·(n-34).
  - Indices 38..40: 0x560+0x20·(n-38).
- R8: Among pending sources with non-zero priority, the highest priority wins. On a tie, the lower index wins. `win_code_o` shows the winner's code while `win_valid_o` is 1.
- R9: Pending set rules:
  - Raising a source that is already pending changes nothing.
  - A clear removes only its own source.
  - A clear in the same cycle as a raise of that source leaves it not pending.
  - Observing the code never removes a source.
- R10: `irq_o` is 1 only when all of the following hold: a winner exists, `block_i` is 0, and `mask_i` is strictly less than the winner's priority.
- R11: Latency:
  - A raise or clear shows on `pending_o` after one clock edge, and on the winner outputs and `irq_o` after the second edge.
  - A change of `mask_i` or `block_i` shows on `irq_o` after one edge.
- R12: Register decode uses only `addr_i[11:0]`, so higher address bits alias. Unmapped offsets read 0.
- R13: A pending source whose priority is later set to 0 stays pending but cannot win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (16) | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` (combinational) |
| raise_i | input | 41 | Per-source raise strobes |
| clear_i | input | 41 | Per-source clear strobes |
| mask_i | input | 4 | CPU interrupt mask level |
| block_i | input | 1 | CPU exception block bit |
| pending_o | output | 41 | Pending vector |
| irq_o | output | 1 | Interrupt request to the CPU |
| win_valid_o | output | 1 | A winner exists |
| win_code_o | output | 12 | Exception code of the winner |

## Verification
The hardest situations to reach from the ports are a tie between sources that share one priority field and a source whose field is zeroed while it is pending. Both depend on register contents lining up with the pending set. The directed part of the stimulus programs a shared DMA field and then raises two of its members in the same cycle. It then rewrites that field to zero and checks that both bits stay pending while the winner disappears. The random part interleaves register writes, raises, clears and mask/block changes, so shared fields often change under pending sources. Every step is compared against a bench model of fields, priorities and codes.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NSRC   = 41;
  localparam int NLINE  = 15;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int PRIO_W = 5;
  localparam int CODE_W = 12;
  localparam int REG_W  = 16;
  localparam int NREG   = 3;

  localparam int S_NMI  = 15;

  localparam logic [11:0] OFS_A = 12'h004;
  localparam logic [11:0] OFS_B = 12'h008;
  localparam logic [11:0] OFS_C = 12'h00C;
  localparam logic [REG_W-1:0] WMASK_B = 16'hFFF0;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [IDX_W-1:0]  idx;
  } node_t;

  // {register, nibble}; nibble 3 = [15:12]
  function automatic logic [3:0] field_sel(input int i);
    logic [3:0] s;
    case (i)
      23:             s = {2'd0, 2'd3};
      24:             s = {2'd0, 2'd2};
      25, 26:         s = {2'd0, 2'd1};
      27, 28, 29:     s = {2'd0, 2'd0};
      38:             s = {2'd1, 2'd3};
      39, 40:         s = {2'd1, 2'd2};
      30, 31, 32, 33: s = {2'd1, 2'd1};
      17:             s = {2'd2, 2'd3};
      18, 19, 20, 21, 22: s = {2'd2, 2'd2};
      34, 35, 36, 37: s = {2'd2, 2'd1};
      default:        s = {2'd2, 2'd0};
    endcase
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
    int n;
    int c;
    n = int'(idx);
    if (n < NLINE)      c = 32'h200 + 32 * n;
    else if (n == S_NMI) c = 32'h1C0;
    else if (n <= 22)   c = 32'h600 + 32 * (n - 16);
    else if (n <= 33)   c = 32'h400 + 32 * (n - 23);
    else if (n <= 37)   c = 32'h700 + 32 * (n - 34);
    else                c = 32'h560 + 32 * (n - 38);
    return CODE_W'(c);
  endfunction

  function automatic node_t pick(input node_t l, input node_t r);
    if (r.valid && (!l.valid || r.prio > l.prio)) return r;
    return l;
  endfunction
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic [NSRC-1:0][PRIO_W-1:0]  prio_o
);
  logic [NREG-1:0][REG_W-1:0] regs_q;
  logic [11:0] ofs;
  logic unused_addr_hi;

  assign ofs = addr_i[11:0];
  assign unused_addr_hi = ^addr_i[ADDR_W-1:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      case (ofs)
        OFS_A:   regs_q[0] <= wdata_i;
        OFS_B:   regs_q[1] <= wdata_i & WMASK_B;
        OFS_C:   regs_q[2] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_A:   rdata_o = regs_q[0];
      OFS_B:   rdata_o = regs_q[1];
      OFS_C:   rdata_o = regs_q[2];
      default: rdata_o = '0;
    endcase
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_prio
    if (i < NLINE) begin : g_line
      assign prio_o[i] = PRIO_W'(NLINE - i);
    end else if (i == S_NMI) begin : g_nmi
      assign prio_o[i] = PRIO_W'(16);
    end else begin : g_field
      localparam logic [3:0] SEL = field_sel(i);
      assign prio_o[i] = {1'b0, regs_q[SEL[3:2]][SEL[1:0]*4 +: 4]};
    end
  end

  a_r4_write_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == OFS_A) |=> (rdata_o == $past(wdata_i) || $past(ofs) != ofs || ofs != OFS_A));
  a_r5_write_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == OFS_B) |=> (regs_q[1] == ($past(wdata_i) & WMASK_B)));
  a_r6_write_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == OFS_C) |=> (regs_q[2] == $past(wdata_i)));
endmodule

// File: rtl/prio_intc_pend.sv
module prio_intc_pend
  import prio_intc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] raise_i,
  input  logic [NSRC-1:0] clear_i,
  input  logic [NSRC-1:0] en_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | (raise_i & en_i)) & ~clear_i;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r2_zero_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_q[i] && raise_i[i] && !en_i[i]) |=> !pend_q[i]);
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i[i] |=> !pend_q[i]);
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[i] && !clear_i[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]             req_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output node_t                    root_o
);
  localparam int LVLS = $clog2(N);
  localparam int PAD  = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int W = PAD >> l;
    node_t nd [W];
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_k
        if (k < N) begin : g_src
          assign nd[k] = '{valid: req_i[k], prio: prio_i[k], idx: IDX_W'(k)};
        end else begin : g_pad
          assign nd[k] = '{valid: 1'b0, prio: '0, idx: '0};
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        // left child holds lower indices: ties resolve left
        assign nd[k] = pick(g_lvl[l-1].nd[2*k], g_lvl[l-1].nd[2*k+1]);
      end
    end
  end

  assign root_o = g_lvl[LVLS].nd[0];
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic [40:0]       raise_i,
  input  logic [40:0]       clear_i,
  input  logic [3:0]        mask_i,
  input  logic              block_i,
  output logic [40:0]       pending_o,
  output logic              irq_o,
  output logic              win_valid_o,
  output logic [11:0]       win_code_o
);
  logic [NSRC-1:0][PRIO_W-1:0] prio_w;
  logic [NSRC-1:0]             en_w;
  logic [NSRC-1:0]             pend_w;
  logic [NSRC-1:0]             elig_w;
  node_t                       root_w;

  logic              win_valid_q;
  logic [PRIO_W-1:0] win_prio_q;
  logic [CODE_W-1:0] win_code_q;
  logic              irq_q;

  prio_intc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .prio_o  (prio_w)
  );

  always_comb begin
    for (int i = 0; i < NSRC; i++) en_w[i] = (prio_w[i] != '0);
  end

  prio_intc_pend u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raise_i (raise_i),
    .clear_i (clear_i),
    .en_i    (en_w),
    .pend_o  (pend_w)
  );

  assign elig_w = pend_w & en_w;

  prio_intc_arb #(.N(NSRC)) u_arb (
    .req_i  (elig_w),
    .prio_i (prio_w),
    .root_o (root_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_q <= 1'b0;
      win_prio_q  <= '0;
      win_code_q  <= '0;
      irq_q       <= 1'b0;
    end else begin
      win_valid_q <= root_w.valid;
      win_prio_q  <= root_w.valid ? root_w.prio : '0;
      win_code_q  <= root_w.valid ? src_code(root_w.idx) : '0;
      irq_q       <= root_w.valid && !block_i && ({1'b0, mask_i} < root_w.prio);
    end
  end

  assign pending_o   = pend_w;
  assign irq_o       = irq_q;
  assign win_valid_o = win_valid_q;
  assign win_code_o  = win_code_q;

  a_r10_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (win_valid_q && !$past(block_i) && ({1'b0, $past(mask_i)} < win_prio_q)));
  a_r13_no_zero_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_q |-> (win_prio_q != '0));
  for (genvar i = 0; i < NSRC; i++) begin : g_top
    a_r8_top_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_valid_q |-> !($past(elig_w[i]) && ($past(prio_w[i]) > win_prio_q)));
  end
endmodule

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;
  localparam int CLK_NS = 20;
  localparam int N = 41;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        wr_en = 0;
  logic [15:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [40:0] raise = 0;
  logic [40:0] clear = 0;
  logic [3:0]  mask = 0;
  logic        block = 0;
  logic [40:0] pending;
  logic        irq;
  logic        wvalid;
  logic [11:0] wcode;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [40:0] m_pend = 0;
  logic [15:0] m_a = 0, m_b = 0, m_c = 0;

  always #(CLK_NS/2) clk = ~clk;

  prio_intc u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .raise_i(raise), .clear_i(clear),
    .mask_i(mask), .block_i(block), .pending_o(pending), .irq_o(irq),
    .win_valid_o(wvalid), .win_code_o(wcode)
  );

  function automatic int e_prio(int i);
    if (i < 15) return 15 - i;
    if (i == 15) return 16;
    case (i)
      16: return int'(m_c[3:0]);
      17: return int'(m_c[15:12]);
      18, 19, 20, 21, 22: return int'(m_c[11:8]);
      23: return int'(m_a[15:12]);
      24: return int'(m_a[11:8]);
      25, 26: return int'(m_a[7:4]);
      27, 28, 29: return int'(m_a[3:0]);
      30, 31, 32, 33: return int'(m_b[7:4]);
      34, 35, 36, 37: return int'(m_c[7:4]);
      38: return int'(m_b[15:12]);
      default: return int'(m_b[11:8]);
    endcase
  endfunction

  function automatic int e_code(int i);
    if (i < 15)  return 'h200 + 'h20 * i;
    if (i == 15) return 'h1C0;
    if (i < 23)  return 'h600 + 'h20 * (i - 16);
    if (i < 34)  return 'h400 + 'h20 * (i - 23);
    if (i < 38)  return 'h700 + 'h20 * (i - 34);
    return 'h560 + 'h20 * (i - 38);
  endfunction

  function automatic int e_win();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && e_prio(i) != 0 && (best < 0 || e_prio(i) > e_prio(best))) best = i;
    return best;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    int w = e_win();
    chk({req, " R9 pending"}, longint'(pending), longint'(m_pend));
    chk({req, " R8 valid"}, longint'(wvalid), (w >= 0) ? 1 : 0);
    if (w >= 0) chk({req, " R7 code"}, longint'(wcode), longint'(e_code(w)));
    chk({req, " R10 irq"}, longint'(irq),
        (w >= 0 && !block && int'(mask) < e_prio(w)) ? 1 : 0);
  endtask

  task automatic model_write(logic [15:0] a, logic [15:0] d);
    case (a[11:0])
      12'h004: m_a = d;
      12'h008: m_b = d & 16'hFFF0;
      12'h00C: m_c = d;
      default: ;
    endcase
  endtask

  // strobes + optional write, settle two edges, then check
  task automatic op(logic [40:0] r, logic [40:0] c, bit wr, logic [15:0] a, logic [15:0] d, string req);
    @(negedge clk);
    raise = r; clear = c; wr_en = wr; addr = a; wdata = d;
    for (int i = 0; i < N; i++)
      if (c[i]) m_pend[i] = 1'b0;
      else if (r[i] && e_prio(i) != 0) m_pend[i] = 1'b1;
    if (wr) model_write(a, d);
    @(negedge clk);
    raise = 0; clear = 0; wr_en = 0;
    @(negedge clk);
    chk_all(req);
  endtask

  task automatic cpu(logic [3:0] m, logic b, string req);
    @(negedge clk);
    mask = m; block = b;
    @(negedge clk);
    @(negedge clk);
    chk_all(req);
  endtask

  task automatic rd(logic [15:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, longint'(rdata), longint'(exp));
  endtask

  function automatic logic [40:0] bit1(int i);
    return 41'd1 << i;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state (during reset)
    chk("R1 pending", longint'(pending), 0);
    chk("R1 irq", longint'(irq), 0);
    chk("R1 valid", longint'(wvalid), 0);
    rst_ni = 1;
    rd(16'h0004, 16'h0, "R1 regA");
    rd(16'h0008, 16'h0, "R1 regB");
    rd(16'h000C, 16'h0, "R1 regC");

    // R2 raise of zero-priority timer 0
    op(bit1(23), 0, 0, 0, 0, "R2 masked raise");
    chk("R2 not pending", longint'(pending[23]), 0);

    // R3/R7 external line 3
    op(bit1(3), 0, 0, 0, 0, "R3 line3");
    chk("R7 line3 code", longint'(wcode), 'h260);
    // R11 mask latency: one edge
    @(negedge clk); mask = 4'd12;
    @(negedge clk);
    chk("R11 mask one edge", longint'(irq), 0);
    @(negedge clk); mask = 4'd11;
    @(negedge clk);
    chk("R11 mask lower", longint'(irq), 1);
    // R9 re-raise
    op(bit1(3), 0, 0, 0, 0, "R9 re-raise");
    // R3 NMI above mask 15
    cpu(4'd15, 1'b0, "R3 mask15");
    chk("R3 line3 blocked by mask15", longint'(irq), 0);
    op(bit1(15), 0, 0, 0, 0, "R3 nmi");
    chk("R3 nmi irq", longint'(irq), 1);
    chk("R7 nmi code", longint'(wcode), 'h1C0);
    // R10 block bit
    cpu(4'd0, 1'b1, "R10 block");
    chk("R10 blocked", longint'(irq), 0);
    // R9 clear removes only its source
    op(0, bit1(15), 0, 0, 0, "R9 clear nmi");
    chk("R9 line3 stays", longint'(pending[3]), 1);
    op(0, bit1(3), 0, 0, 0, "R9 clear line3");
    cpu(4'd0, 1'b0, "R10 unblock");

    // R12 alias and reserved bits
    op(0, 0, 1, 16'h1004, 16'h1234, "R12 alias write");
    rd(16'h0004, 16'h1234, "R12 alias readback");
    op(0, 0, 1, 16'h0008, 16'hABCD, "R5 write B");
    rd(16'h0008, 16'hABC0, "R5 reserved bits");
    rd(16'h0010, 16'h0, "R12 unmapped");

    // R6/R8 tie in shared DMA field
    op(0, 0, 1, 16'h000C, 16'h0500, "R6 write C");
    op(bit1(20) | bit1(19), 0, 0, 0, 0, "R8 tie");
    chk("R8 tie lower index", longint'(wcode), 'h660);
    // R13 zero the field while pending
    op(0, 0, 1, 16'h000C, 16'h0000, "R13 zero field");
    chk("R13 still pending", longint'(pending[20:19]), 3);
    chk("R13 no winner", longint'(wvalid), 0);
    op(0, bit1(19) | bit1(20), 0, 0, 0, "R9 cleanup");

    // R9 raise and clear in the same cycle
    op(bit1(5), bit1(5), 0, 0, 0, "R9 raise+clear");
    chk("R9 clear wins", longint'(pending[5]), 0);

    // R11 raise latency
    @(negedge clk); raise = bit1(7);
    @(negedge clk); raise = 0; m_pend[7] = 1'b1;
    chk("R11 pending after one edge", longint'(pending[7]), 1);
    chk("R11 winner not yet", longint'(wvalid), 0);
    @(negedge clk);
    chk("R11 winner after two", longint'(wcode), 'h2E0);

    // R4 timer field vs external line
    op(0, 0, 1, 16'h0004, 16'hF000, "R4 write A");
    op(bit1(23), 0, 0, 0, 0, "R4 timer0 prio15");
    chk("R8 timer0 beats line7", longint'(wcode), 'h400);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int kind = $urandom_range(0, 9);
      if (kind < 4) begin
        logic [40:0] r = bit1($urandom_range(0, N - 1));
        if ($urandom_range(0, 1) == 1) r |= bit1($urandom_range(0, N - 1));
        op(r, 0, 0, 0, 0, "R8 rnd raise");
      end else if (kind < 7) begin
        op(0, bit1($urandom_range(0, N - 1)), 0, 0, 0, "R9 rnd clear");
      end else if (kind < 9) begin
        logic [15:0] a;
        case ($urandom_range(0, 3))
          0: a = 16'h0004;
          1: a = 16'h0008;
          2: a = 16'h000C;
          default: a = 16'h0014;
        endcase
        a[15:12] = 4'($urandom_range(0, 15));
        op(0, 0, 1, a, 16'($urandom), "R4 rnd write");
      end else begin
        cpu(4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0), "R10 rnd cpu");
      end
    end
    rd(16'h0004, m_a, "R4 final A");
    rd(16'h0008, m_b, "R5 final B");
    rd(16'h000C, m_c, "R6 final C");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule